// File: doc/BRIEF.md
# Nibble-RAM Dual Stack Engine

This block is the data-stack back end of a small 4-bit stack-oriented processor. One 256-word by 4-bit data memory holds both an expression stack of nibbles and a return stack of 12-bit entries. The current top of the expression stack is kept in its own register (`tos`), which works like an accumulator. The element below it (`nos`) is read straight from memory at the expression pointer. Both values go to an external ALU, and the ALU result returns on `alu_res`.

The decoder above the block issues one micro-operation per clock on `op`. Every operation finishes in that cycle, so no back-pressure exists and the op port has no valid/ready pair. `OP_NOP` is the idle code. Software sets where each stack lives, and how deep it may grow, by loading the pointers and driving the four limit inputs. Two general address registers, `x` and `y`, give direct memory fetch and store. A pointer that runs past a limit raises an error pulse. The block does not correct the pointer.

Top module: `nds_dual_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tos`, `sp`, `rp`, `x`, `y`, `es_err` and `rs_err` all become 0.
- R2: Op code 1 (literal push) writes the old `tos` to memory at `sp+1`, increments `sp` and loads `din` into `tos`. All results are visible after the next edge.
- R3: Op code 2 (drop) loads `tos` from memory at `sp` and decrements `sp`. `nos` always shows memory at `sp`.
- R4: Op code 3 (dup) pushes a copy of `tos`. Op code 4 (swap) exchanges `tos` with memory at `sp` and leaves `sp` unchanged.
- R5: Op code 5 loads `alu_res` into `tos` and leaves `sp` unchanged. Op code 6 loads `alu_res` into `tos` and decrements `sp`, which discards the consumed second operand.
- R6: Op code 7 adds 4 to `rp` and stores `ret_in` as three nibbles, low nibble first, at the new `rp`, `rp+1` and `rp+2`. `rtop` always shows those three nibbles at the current `rp`.
- R7: Op code 8 subtracts 4 from `rp`.
- R8: Op code 9 moves `tos` to the return stack as a zero-extended entry and pops the expression stack. Op code 10 pushes the low nibble of `rtop` onto the expression stack and pops the return stack.
- R9: Op codes 11 and 13 push memory at `x` or `y` onto the expression stack. Op codes 12 and 14 store `tos` at `x` or `y` and pop the expression stack.
- R10: Op code 15 loads `addr_in` into the pointer selected by `ptr_sel`: 0 selects `sp`, 1 `rp`, 2 `x` and 3 `y`.
- R11: `es_err` is high for exactly the cycle after an expression push issued with `sp == es_ceil` or an expression pop issued with `sp == es_floor`. The pointer still moves, wrapping modulo 256.
- R12: `rs_err` is high for exactly the cycle after a return push issued with `rp == rs_ceil` or a return pop issued with `rp == rs_floor`. The pointer still moves.
- R13: Op code 0 changes no pointer, no `tos` and no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 4 | Micro-operation code |
| din | input | 4 | Literal for a push |
| alu_res | input | 4 | Result from the external ALU |
| ret_in | input | 12 | Entry for a return push |
| ptr_sel | input | 2 | Pointer chosen by a pointer load |
| addr_in | input | 8 | Value for a pointer load |
| es_floor | input | 8 | Expression-stack underflow limit |
| es_ceil | input | 8 | Expression-stack overflow limit |
| rs_floor | input | 8 | Return-stack underflow limit |
| rs_ceil | input | 8 | Return-stack overflow limit |
| tos | output | 4 | Top of expression stack |
| nos | output | 4 | Second expression-stack element |
| rtop | output | 12 | Top return-stack entry |
| sp | output | 8 | Expression pointer |
| rp | output | 8 | Return pointer |
| x | output | 8 | Address register X |
| y | output | 8 | Address register Y |
| es_err | output | 1 | Expression limit crossed |
| rs_err | output | 1 | Return limit crossed |

## Verification
Every register result of an operation (`tos`, the pointers, the error pulses and written memory) is due exactly one edge after the cycle in which the op is presented. The combinational views `nos` and `rtop` follow the new pointers within that same cycle. The bench drives each op on a falling edge and updates its reference model at the rising edge. It compares all outputs at the next falling edge, so every result is checked exactly one cycle after its stimulus. Memory words that have never been written are tracked as unknown, and comparisons that depend on them are skipped.

// File: rtl/nds_pkg.sv
package nds_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_LIT    = 4'd1,
    OP_DROP   = 4'd2,
    OP_DUP    = 4'd3,
    OP_SWAP   = 4'd4,
    OP_ALU1   = 4'd5,
    OP_ALU2   = 4'd6,
    OP_RPUSH  = 4'd7,
    OP_RPOP   = 4'd8,
    OP_TOR    = 4'd9,
    OP_FROMR  = 4'd10,
    OP_FETCHX = 4'd11,
    OP_STOREX = 4'd12,
    OP_FETCHY = 4'd13,
    OP_STOREY = 4'd14,
    OP_LDPTR  = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    TS_HOLD, TS_DIN, TS_NOS, TS_ALU, TS_RLOW, TS_MX, TS_MY
  } tos_sel_e;

  typedef struct packed {
    logic     es_push;
    logic     es_pop;
    logic     rs_push;
    logic     rs_pop;
    logic     wr_up;        // old tos to sp+1
    logic     wr_at;        // tos to sp
    logic     wr_mx;        // tos to x
    logic     wr_my;        // tos to y
    logic     ret_wr;       // write a return slot
    logic     ret_from_tos; // slot data is zero-extended tos
    logic     ld;           // pointer load
    tos_sel_e tsel;
  } ctl_t;

  // Return slot spacing: next power of two covering the nibbles of one entry
  function automatic int slot_step(input int nibbles);
    return 1 << $clog2(nibbles);
  endfunction

endpackage

// File: rtl/nds_ram.sv
module nds_ram #(
  parameter int AW  = 8,
  parameter int DW  = 4,
  parameter int NWR = 4,
  parameter int NRD = 6
) (
  input  logic          clk,
  input  logic          we [NWR],
  input  logic [AW-1:0] wa [NWR],
  input  logic [DW-1:0] wd [NWR],
  input  logic [AW-1:0] ra [NRD],
  output logic [DW-1:0] rd [NRD]
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < NWR; p++) begin
      if (we[p]) mem[wa[p]] <= wd[p];
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd[g] = mem[ra[g]];
  end
endmodule

// File: rtl/nds_ctrl.sv
module nds_ctrl
  import nds_pkg::*;
(
  input  logic [3:0] op,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    ctl.tsel = TS_HOLD;
    case (op_e'(op))
      OP_LIT:    begin ctl.es_push = 1'b1; ctl.wr_up = 1'b1; ctl.tsel = TS_DIN; end
      OP_DROP:   begin ctl.es_pop  = 1'b1; ctl.tsel = TS_NOS; end
      OP_DUP:    begin ctl.es_push = 1'b1; ctl.wr_up = 1'b1; end
      OP_SWAP:   begin ctl.wr_at   = 1'b1; ctl.tsel = TS_NOS; end
      OP_ALU1:   ctl.tsel = TS_ALU;
      OP_ALU2:   begin ctl.es_pop  = 1'b1; ctl.tsel = TS_ALU; end
      OP_RPUSH:  begin ctl.rs_push = 1'b1; ctl.ret_wr = 1'b1; end
      OP_RPOP:   ctl.rs_pop = 1'b1;
      OP_TOR: begin
        ctl.rs_push = 1'b1; ctl.ret_wr = 1'b1; ctl.ret_from_tos = 1'b1;
        ctl.es_pop = 1'b1; ctl.tsel = TS_NOS;
      end
      OP_FROMR: begin
        ctl.rs_pop = 1'b1; ctl.es_push = 1'b1; ctl.wr_up = 1'b1;
        ctl.tsel = TS_RLOW;
      end
      OP_FETCHX: begin ctl.es_push = 1'b1; ctl.wr_up = 1'b1; ctl.tsel = TS_MX; end
      OP_FETCHY: begin ctl.es_push = 1'b1; ctl.wr_up = 1'b1; ctl.tsel = TS_MY; end
      OP_STOREX: begin ctl.wr_mx = 1'b1; ctl.es_pop = 1'b1; ctl.tsel = TS_NOS; end
      OP_STOREY: begin ctl.wr_my = 1'b1; ctl.es_pop = 1'b1; ctl.tsel = TS_NOS; end
      OP_LDPTR:  ctl.ld = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/nds_ptr_unit.sv
module nds_ptr_unit #(
  parameter int AW    = 8,
  parameter int RSTEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          es_push,
  input  logic          es_pop,
  input  logic          rs_push,
  input  logic          rs_pop,
  input  logic          ld,
  input  logic [1:0]    ld_sel,
  input  logic [AW-1:0] ld_val,
  input  logic [AW-1:0] es_floor,
  input  logic [AW-1:0] es_ceil,
  input  logic [AW-1:0] rs_floor,
  input  logic [AW-1:0] rs_ceil,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] rp,
  output logic [AW-1:0] x,
  output logic [AW-1:0] y,
  output logic          es_err,
  output logic          rs_err
);
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] STEP = AW'(RSTEP);

  logic [AW-1:0] sp_nx, rp_nx;

  always_comb begin
    sp_nx = sp;
    if (es_push)     sp_nx = sp + ONE;
    else if (es_pop) sp_nx = sp - ONE;
    rp_nx = rp;
    if (rs_push)     rp_nx = rp + STEP;
    else if (rs_pop) rp_nx = rp - STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0; rp <= '0; x <= '0; y <= '0;
      es_err <= 1'b0; rs_err <= 1'b0;
    end else begin
      es_err <= (es_push && sp == es_ceil) || (es_pop && sp == es_floor);
      rs_err <= (rs_push && rp == rs_ceil) || (rs_pop && rp == rs_floor);
      if (ld) begin
        case (ld_sel)
          2'd0: sp <= ld_val;
          2'd1: rp <= ld_val;
          2'd2: x  <= ld_val;
          default: y <= ld_val;
        endcase
      end else begin
        sp <= sp_nx;
        rp <= rp_nx;
      end
    end
  end
endmodule

// File: rtl/nds_dual_stack.sv
module nds_dual_stack
  import nds_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 4,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] alu_res,
  input  logic [RW-1:0] ret_in,
  input  logic [1:0]    ptr_sel,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] es_floor,
  input  logic [AW-1:0] es_ceil,
  input  logic [AW-1:0] rs_floor,
  input  logic [AW-1:0] rs_ceil,
  output logic [DW-1:0] tos,
  output logic [DW-1:0] nos,
  output logic [RW-1:0] rtop,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] rp,
  output logic [AW-1:0] x,
  output logic [AW-1:0] y,
  output logic          es_err,
  output logic          rs_err
);
  localparam int RNIB  = RW / DW;
  localparam int RSTEP = slot_step(RNIB);
  localparam int NWR   = 1 + RNIB;
  localparam int NRD   = 3 + RNIB;   // sp, x, y, then return nibbles

  ctl_t          ctl;
  logic          we [NWR];
  logic [AW-1:0] wa [NWR];
  logic [DW-1:0] wd [NWR];
  logic [AW-1:0] ra [NRD];
  logic [DW-1:0] rd [NRD];

  nds_ctrl i_ctrl (.op(op), .ctl(ctl));

  nds_ptr_unit #(.AW(AW), .RSTEP(RSTEP)) i_ptr (
    .clk(clk), .rst_n(rst_n),
    .es_push(ctl.es_push), .es_pop(ctl.es_pop),
    .rs_push(ctl.rs_push), .rs_pop(ctl.rs_pop),
    .ld(ctl.ld), .ld_sel(ptr_sel), .ld_val(addr_in),
    .es_floor(es_floor), .es_ceil(es_ceil),
    .rs_floor(rs_floor), .rs_ceil(rs_ceil),
    .sp(sp), .rp(rp), .x(x), .y(y),
    .es_err(es_err), .rs_err(rs_err)
  );

  // Expression-side write port
  always_comb begin
    we[0] = ctl.wr_up | ctl.wr_at | ctl.wr_mx | ctl.wr_my;
    wd[0] = tos;
    if (ctl.wr_up)      wa[0] = sp + AW'(1);
    else if (ctl.wr_at) wa[0] = sp;
    else if (ctl.wr_mx) wa[0] = x;
    else                wa[0] = y;
  end

  assign ra[0] = sp;
  assign ra[1] = x;
  assign ra[2] = y;
  assign nos   = rd[0];

  // One write port and one read port per nibble of a return entry
  for (genvar k = 0; k < RNIB; k++) begin : g_ret
    assign we[1+k] = ctl.ret_wr;
    assign wa[1+k] = rp + AW'(RSTEP) + AW'(k);
    if (k == 0) begin : g_low
      assign wd[1+k] = ctl.ret_from_tos ? tos : ret_in[DW-1:0];
    end else begin : g_hi
      assign wd[1+k] = ctl.ret_from_tos ? '0 : ret_in[k*DW +: DW];
    end
    assign ra[3+k] = rp + AW'(k);
    assign rtop[k*DW +: DW] = rd[3+k];
  end

  nds_ram #(.AW(AW), .DW(DW), .NWR(NWR), .NRD(NRD)) i_ram (
    .clk(clk), .we(we), .wa(wa), .wd(wd), .ra(ra), .rd(rd)
  );

  logic [DW-1:0] tos_nx;
  always_comb begin
    case (ctl.tsel)
      TS_DIN:  tos_nx = din;
      TS_NOS:  tos_nx = rd[0];
      TS_ALU:  tos_nx = alu_res;
      TS_RLOW: tos_nx = rd[3];
      TS_MX:   tos_nx = rd[1];
      TS_MY:   tos_nx = rd[2];
      default: tos_nx = tos;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tos <= '0;
    else        tos <= tos_nx;
  end
endmodule

// File: rtl/nds_dual_stack_chk.sv
module nds_dual_stack_chk
  import nds_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op,
  input logic [3:0]  din,
  input logic [3:0]  alu_res,
  input logic [11:0] ret_in,
  input logic [1:0]  ptr_sel,
  input logic [7:0]  addr_in,
  input logic [7:0]  es_ceil,
  input logic [7:0]  rs_floor,
  input logic [3:0]  tos,
  input logic [11:0] rtop,
  input logic [7:0]  sp,
  input logic [7:0]  rp,
  input logic [7:0]  x,
  input logic        es_err,
  input logic        rs_err
);
  AST_LIT_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LIT |=> tos == $past(din) && sp == 8'($past(sp) + 8'd1)); // R2
  AST_DROP_SP: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_DROP |=> sp == 8'($past(sp) - 8'd1)); // R3
  AST_SWAP_SP: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SWAP |=> $stable(sp)); // R4
  AST_ALU_POP: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ALU2 |=> tos == $past(alu_res) && sp == 8'($past(sp) - 8'd1)); // R5
  AST_RET_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_RPUSH |=> rp == 8'($past(rp) + 8'd4) && rtop == $past(ret_in)); // R6
  AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_RPOP |=> rp == 8'($past(rp) - 8'd4)); // R7
  AST_LOAD_X: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LDPTR && ptr_sel == 2'd2) |=> x == $past(addr_in)); // R10
  AST_ES_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LIT && sp == es_ceil) |=> es_err); // R11
  AST_RS_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RPOP && rp == rs_floor) |=> rs_err); // R12
  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_NOP |=> $stable(tos) && $stable(sp) && $stable(rp) && !es_err && !rs_err); // R13
endmodule

bind nds_dual_stack nds_dual_stack_chk i_chk (.*);

// File: tb/test_nds_dual_stack.sv
`timescale 1ns/1ps
module test_nds_dual_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0, din = 4'd0, alu_res = 4'd0;
  logic [11:0] ret_in = 12'd0;
  logic [1:0]  ptr_sel = 2'd0;
  logic [7:0]  addr_in = 8'd0;
  logic [7:0]  es_floor = 8'h10, es_ceil = 8'h18, rs_floor = 8'h80, rs_ceil = 8'h8C;
  logic [3:0]  tos, nos;
  logic [11:0] rtop;
  logic [7:0]  sp, rp, x, y;
  logic        es_err, rs_err;

  always #10 clk = ~clk;

  nds_dual_stack i_nds_dual_stack (.*);

  int n_chk = 0, n_fail = 0;
  int mem [256];
  bit known [256];
  int m_tos, m_sp, m_rp, m_x, m_y;
  bit m_tos_ok, m_ees, m_ers;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int rdm(input int a);
    return mem[a & 255];
  endfunction

  task automatic wrm(input int a, input int v);
    mem[a & 255] = v & 15;
    known[a & 255] = 1'b1;
  endtask

  // Behavioural reference: applies one operation to the model
  task automatic model_apply(input int o, input int di, input int al,
                             input int ri, input int ps, input int ai);
    int s = m_sp, r = m_rp, t = m_tos;
    bit tk = m_tos_ok;
    bit ep = 0, eo = 0, rpu = 0, rpo = 0;
    case (o)
      1: begin wrm(s + 1, t); m_sp = s + 1; m_tos = di; m_tos_ok = 1; ep = 1; end
      2: begin m_tos = rdm(s); m_tos_ok = known[s]; m_sp = s - 1; eo = 1; end
      3: begin wrm(s + 1, t); m_sp = s + 1; ep = 1; end
      4: begin m_tos = rdm(s); m_tos_ok = known[s]; wrm(s, t); end
      5: begin m_tos = al; m_tos_ok = 1; end
      6: begin m_tos = al; m_tos_ok = 1; m_sp = s - 1; eo = 1; end
      7: begin m_rp = r + 4; for (int k = 0; k < 3; k++) wrm(r + 4 + k, ri >> (4 * k)); rpu = 1; end
      8: begin m_rp = r - 4; rpo = 1; end
      9: begin
           m_rp = r + 4; wrm(r + 4, t); wrm(r + 5, 0); wrm(r + 6, 0); rpu = 1;
           m_tos = rdm(s); m_tos_ok = known[s]; m_sp = s - 1; eo = 1;
         end
      10: begin
            m_tos = rdm(r); m_tos_ok = known[r & 255]; wrm(s + 1, t);
            m_sp = s + 1; ep = 1; m_rp = r - 4; rpo = 1;
          end
      11: begin m_tos = rdm(m_x); m_tos_ok = known[m_x]; wrm(s + 1, t); m_sp = s + 1; ep = 1; end
      13: begin m_tos = rdm(m_y); m_tos_ok = known[m_y]; wrm(s + 1, t); m_sp = s + 1; ep = 1; end
      12: begin m_tos = rdm(s); m_tos_ok = known[s]; wrm(m_x, t); m_sp = s - 1; eo = 1; end
      14: begin m_tos = rdm(s); m_tos_ok = known[s]; wrm(m_y, t); m_sp = s - 1; eo = 1; end
      15: case (ps)
            0: m_sp = ai; 1: m_rp = ai; 2: m_x = ai; default: m_y = ai;
          endcase
      default: ;
    endcase
    if (!tk && (o == 1 || o == 3 || o == 4 || (o >= 9 && o <= 14))) begin
      // an unknown tos written to memory makes that word unknown
      if (o == 4) known[s & 255] = 0;
      else if (o == 12) known[m_x] = 0;
      else if (o == 14) known[m_y] = 0;
      else if (o == 9) known[(r + 4) & 255] = 0;
      else known[(s + 1) & 255] = 0;
    end
    if (o == 3) m_tos_ok = tk;
    m_sp &= 255; m_rp &= 255;
    m_ees = (ep && s == es_ceil) || (eo && s == es_floor);
    m_ers = (rpu && r == rs_ceil) || (rpo && r == rs_floor);
  endtask

  task automatic compare_all(input string req);
    check(sp == m_sp[7:0], {req, " sp"}, sp, m_sp);
    check(rp == m_rp[7:0], {req, " rp"}, rp, m_rp);
    check(x == m_x[7:0] && y == m_y[7:0], {req, " R10 x/y"}, {x, y}, {m_x[7:0], m_y[7:0]});
    check(es_err == m_ees, {req, " R11 es_err"}, es_err, m_ees);
    check(rs_err == m_ers, {req, " R12 rs_err"}, rs_err, m_ers);
    if (m_tos_ok) check(tos == m_tos[3:0], {req, " tos"}, tos, m_tos);
    if (known[m_sp]) check(nos == mem[m_sp][3:0], {req, " R3 nos"}, nos, mem[m_sp]);
    if (known[m_rp] && known[(m_rp + 1) & 255] && known[(m_rp + 2) & 255])
      check(rtop == {mem[(m_rp + 2) & 255][3:0], mem[(m_rp + 1) & 255][3:0], mem[m_rp][3:0]},
            {req, " R6 rtop"}, rtop,
            {mem[(m_rp + 2) & 255][3:0], mem[(m_rp + 1) & 255][3:0], mem[m_rp][3:0]});
  endtask

  task automatic step(input string req, input int o, input int di = 0, input int al = 0,
                      input int ri = 0, input int ps = 0, input int ai = 0);
    op = 4'(o); din = 4'(di); alu_res = 4'(al); ret_in = 12'(ri);
    ptr_sel = 2'(ps); addr_in = 8'(ai);
    @(posedge clk);
    model_apply(o, di, al, ri, ps, ai);
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 0; known[i] = 0; end
    m_tos = 0; m_sp = 0; m_rp = 0; m_x = 0; m_y = 0;
    m_tos_ok = 1; m_ees = 0; m_ers = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    // R10 pointer loads
    step("R10 ld sp", 15, 0, 0, 0, 0, 8'h10);
    step("R10 ld rp", 15, 0, 0, 0, 1, 8'h80);
    step("R10 ld x",  15, 0, 0, 0, 2, 8'h40);
    step("R10 ld y",  15, 0, 0, 0, 3, 8'h48);
    // R2 literal pushes
    step("R2 lit", 1, 5);
    step("R2 lit", 1, 4'hA);
    step("R2 lit", 1, 3);
    step("R4 dup", 3);
    step("R4 swap", 4);
    step("R13 nop", 0);
    step("R5 alu1", 5, 0, 7);
    step("R5 alu2", 6, 0, 4'hC);
    step("R3 drop", 2);
    // R9 memory via x and y
    step("R2 lit", 1, 9);
    step("R9 storex", 12);
    step("R9 fetchx", 11);
    step("R2 lit", 1, 6);
    step("R9 storey", 14);
    step("R9 fetchy", 13);
    // R6 R7 R8 return stack
    step("R6 rpush", 7, 0, 0, 12'hABC);
    step("R6 rpush", 7, 0, 0, 12'h123);
    step("R8 tor", 9);
    step("R8 fromr", 10);
    step("R7 rpop", 8);
    step("R7 rpop", 8);
    step("R12 rpop at floor", 8);
    // R11 overflow: push up to and past the ceiling
    step("R10 ld sp", 15, 0, 0, 0, 0, 8'h10);
    for (int i = 0; i < 10; i++) step("R11 push", 1, i);
    for (int i = 0; i < 11; i++) step("R11 pop", 2);
    // R12 return overflow
    step("R10 ld rp", 15, 0, 0, 0, 1, 8'h80);
    for (int i = 0; i < 4; i++) step("R12 rpush", 7, 0, 0, 12'h5A0 + i);
    step("R13 nop", 0);
    // mixed sequence
    for (int i = 0; i < 400; i++) begin
      int o = $urandom_range(0, 15);
      step("R13 mix", o, $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 4095), $urandom_range(0, 3), $urandom_range(0, 255));
    end
    rst_n = 1'b0;
    @(posedge clk);
    m_tos = 0; m_sp = 0; m_rp = 0; m_x = 0; m_y = 0; m_tos_ok = 1; m_ees = 0; m_ers = 0;
    @(negedge clk);
    compare_all("R1 reset again");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule